// File: doc/BRIEF.md
# Two-Stage I2C SCL Rate Divider

This block derives the SCL timing for an I2C master from the system clock. Two programmable divisors sit in a 16-bit control word: a 2-bit prescale value A and a 6-bit value B. Each divisor acts as its field value plus one. They are cascaded into a prescaled tick. A divide-by-22 phase counter then splits every SCL period into 22 ticks, so one SCL period lasts 22·(A+1)·(B+1) input clocks. Software picks A and B so that the SCL rate stays at or below 400 kHz. The block does not compute them.

The block has two outputs. `tick_o` is a strobe that marks each phase step, one per prescaled tick. `scl_o` is a free-running SCL waveform that the bit engine gates. The waveform is low for the first 11 ticks of each period and high for the last 11.

The divisor values are sampled into shadow registers in two cases: while the divider is disabled, and at the end of each SCL period. A field rewritten while the divider runs therefore never cuts a period short. When the divider is disabled, every counter clears and SCL rests high.

Top module: `scl_rate_div`

## Requirements
- R1: While `rst_ni` is low, `scl_o` is 1 and `tick_o` is 0, whatever `en_i` is.
- R2: After any clock edge with `en_i` low, `scl_o` is 1 and `tick_o` is 0, for any `ctrl_i` value. Re-enabling restarts all counting from zero.
- R3: Let N = (A+1)·(B+1). After `en_i` is first sampled high, `tick_o` is first high in the cycle that follows the N-th rising edge with `en_i` high. After that it is high once every N cycles.
- R4: A is `ctrl_i[15:14]` and B is `ctrl_i[13:8]`. Bits 7:0 of `ctrl_i` have no effect.
- R5: `scl_o` is low from the first enabled cycle until the 11th tick. It is high from the 11th tick until the 22nd tick, where it falls again. Each SCL period is 22·N cycles and each half is 11·N cycles.
- R6: A change of `ctrl_i` while enabled takes effect only after the last tick of the current SCL period. The next tick then comes N_new cycles later.
- R7: For N > 1, `tick_o` is high for exactly one cycle per tick.
- R8: While enabled, `scl_o` changes level only in a cycle in which `tick_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Divider enable; low clears the counters and holds SCL high |
| ctrl_i | input | 16 | Control word; A in bits 15:14, B in bits 13:8 |
| tick_o | output | 1 | Phase strobe, one per prescaled tick |
| scl_o | output | 1 | Free-running SCL waveform |

## Verification
Every output comes from a register one edge behind the counters. The bench raises `en_i` at a falling edge and numbers the following falling edges from one. The k-th tick is then expected at edge k·N, the SCL rise at 11·N and the next fall at 22·N. Disabling is checked at the first falling edge after `en_i` drops. For a divisor change, the first tick of the new period is expected N_new edges after the 22nd tick of the old period. Each of these positions is computed from A and B and sampled exactly there, together with the edge just before it, so both a late result and an early one are caught.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int CTRL_W   = 16;
  localparam int DIVA_W   = 2;
  localparam int DIVA_LSB = 14;
  localparam int DIVB_W   = 6;
  localparam int DIVB_LSB = 8;
  localparam int PHASES   = 22;
  localparam int HALF     = PHASES / 2;
endpackage

// File: rtl/scl_div_stage.sv
module scl_div_stage #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  assign hit_o = step_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_i)  cnt_q <= hit_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/scl_div_phase.sv
module scl_div_phase #(
  parameter int PHASES = 22,
  localparam int PW = $clog2(PHASES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  output logic [PW-1:0] ph_o,
  output logic          wrap_o
);
  logic [PW-1:0] ph_q;

  assign wrap_o = step_i && (ph_q == PW'(PHASES - 1));
  assign ph_o   = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ph_q <= '0;
    else if (clr_i)   ph_q <= '0;
    else if (step_i)  ph_q <= wrap_o ? '0 : ph_q + 1'b1;
  end
endmodule

// File: rtl/scl_rate_div.sv
module scl_rate_div
  import scl_div_pkg::*;
#(
  parameter int CW     = CTRL_W,
  parameter int AW     = DIVA_W,
  parameter int A_LSB  = DIVA_LSB,
  parameter int BW     = DIVB_W,
  parameter int B_LSB  = DIVB_LSB,
  parameter int NPH    = PHASES,
  localparam int NHALF = NPH / 2,
  localparam int PW    = $clog2(NPH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [CW-1:0] ctrl_i,
  output logic          tick_o,
  output logic          scl_o
);
  logic [AW-1:0] div_a_q;
  logic [BW-1:0] div_b_q;
  logic          hit_a, hit_b, wrap;
  logic [PW-1:0] ph;
  logic          tick_q, run_q;

  scl_div_stage #(.W(AW)) u_stage_a (
    .clk_i, .rst_ni, .clr_i(!en_i), .step_i(en_i),
    .limit_i(div_a_q), .hit_o(hit_a)
  );

  scl_div_stage #(.W(BW)) u_stage_b (
    .clk_i, .rst_ni, .clr_i(!en_i), .step_i(hit_a),
    .limit_i(div_b_q), .hit_o(hit_b)
  );

  scl_div_phase #(.PHASES(NPH)) u_phase (
    .clk_i, .rst_ni, .clr_i(!en_i), .step_i(hit_b),
    .ph_o(ph), .wrap_o(wrap)
  );

  // shadow divisors: follow the field while idle, reload only at period end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_a_q <= '0;
      div_b_q <= '0;
    end else if (!en_i || wrap) begin
      div_a_q <= ctrl_i[A_LSB +: AW];
      div_b_q <= ctrl_i[B_LSB +: BW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      tick_q <= hit_b;
      run_q  <= en_i;
    end
  end

  assign tick_o = tick_q;
  assign scl_o  = !run_q || (ph >= PW'(NHALF));
endmodule

// File: rtl/scl_rate_div_chk.sv
module scl_rate_div_chk #(
  parameter int AW = 2,
  parameter int BW = 6,
  localparam int MAX_N = (1 << AW) * (1 << BW),
  localparam int GW = $clog2(MAX_N + 2)
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic tick_o,
  input logic scl_o
);
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                gap_q <= '0;
    else if (!en_i || tick_o)   gap_q <= '0;
    else if (gap_q != '1)       gap_q <= gap_q + 1'b1;
  end

  a_r1_reset_idle: assert property (@(posedge clk_i) !rst_ni |-> scl_o && !tick_o);

  a_r2_disabled_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> scl_o && !tick_o);

  a_r8_scl_moves_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && $past(en_i) && $past(en_i, 2) && (scl_o != $past(scl_o)) |-> tick_o);

  a_r3_tick_gap_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q <= GW'(MAX_N));
endmodule

bind scl_rate_div scl_rate_div_chk #(.AW(AW), .BW(BW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .tick_o(tick_o), .scl_o(scl_o)
);

// File: tb/scl_rate_div_test.sv
module scl_rate_div_test;
  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en = 1'b0;
  logic [15:0] ctrl = '0;
  logic        tick_o, scl_o;
  int          checks = 0;
  int          bad = 0;

  always #(CLK_P / 2) clk = ~clk;

  scl_rate_div uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .ctrl_i(ctrl),
    .tick_o(tick_o), .scl_o(scl_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int a, input int b, input logic [7:0] junk);
    return {a[1:0], b[5:0], junk};
  endfunction

  task automatic t_reset();
    en = 1'b1;
    ctrl = mk(0, 0, 8'h00);
    repeat (3) @(negedge clk);
    chk(scl_o == 1'b1, "R1 scl in reset", int'(scl_o), 1);
    chk(tick_o == 1'b0, "R1 tick in reset", int'(tick_o), 0);
    en = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_disabled();
    bit seen_bad = 0;
    en = 1'b0;
    for (int i = 0; i < 40; i++) begin
      ctrl = 16'(i * 1237);
      @(negedge clk);
      if (tick_o || !scl_o) seen_bad = 1;
    end
    chk(!seen_bad, "R2 idle outputs", int'(seen_bad), 0);
  endtask

  task automatic t_rate(input int a, input int b, input logic [7:0] junk);
    int n = (a + 1) * (b + 1);
    int first = -1, second = -1, ticks = 0;
    bit dbl = 0;
    logic prev_t = 1'b0;
    en = 1'b0;
    ctrl = mk(a, b, junk);
    repeat (2) @(negedge clk);
    en = 1'b1;
    for (int j = 1; j <= 22 * n; j++) begin
      @(negedge clk);
      if (tick_o) begin
        ticks++;
        if (first < 0) first = j;
        else if (second < 0) second = j;
        if (prev_t && n > 1) dbl = 1;
      end
      prev_t = tick_o;
      if (j == 1)          chk(scl_o == 1'b0, "R5 scl low at start", int'(scl_o), 0);
      if (j == 11 * n - 1 && j > 1) chk(scl_o == 1'b0, "R5 scl low before half", int'(scl_o), 0);
      if (j == 11 * n)     chk(scl_o == 1'b1, "R5 scl rises at half", int'(scl_o), 1);
      if (j == 22 * n - 1) chk(scl_o == 1'b1, "R5 scl high before end", int'(scl_o), 1);
      if (j == 22 * n)     chk(scl_o == 1'b0, "R5 scl falls at period end", int'(scl_o), 0);
    end
    chk(first == n, "R3 R4 first tick", first, n);
    chk(second == 2 * n, "R3 second tick", second, 2 * n);
    chk(ticks == 22, "R3 ticks per period", ticks, 22);
    chk(!dbl, "R7 single-cycle tick", int'(dbl), 0);
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_change();
    // N=2 (A=0,B=1), switched to N=4 (A=1,B=1) mid period
    int ticks = 0, first_new = -1;
    en = 1'b0;
    ctrl = mk(0, 1, 8'h00);
    repeat (2) @(negedge clk);
    en = 1'b1;
    for (int j = 1; j <= 60; j++) begin
      @(negedge clk);
      if (j == 10) ctrl = mk(1, 1, 8'h00);
      if (tick_o && j <= 44) ticks++;
      if (tick_o && j > 44 && first_new < 0) first_new = j;
      if (j == 44) chk(scl_o == 1'b0, "R6 old period ends at 44", int'(scl_o), 0);
      if (j == 46) chk(tick_o == 1'b0, "R6 no tick at old spacing", int'(tick_o), 0);
    end
    chk(ticks == 22, "R6 old period kept", ticks, 22);
    chk(first_new == 48, "R6 new spacing after boundary", first_new, 48);
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_disable_mid();
    int first = -1;
    en = 1'b0;
    ctrl = mk(1, 0, 8'h5A);
    repeat (2) @(negedge clk);
    en = 1'b1;
    repeat (30) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(scl_o == 1'b1, "R2 scl high after disable", int'(scl_o), 1);
    chk(tick_o == 1'b0, "R2 tick low after disable", int'(tick_o), 0);
    @(negedge clk);
    en = 1'b1;
    for (int j = 1; j <= 6; j++) begin
      @(negedge clk);
      if (tick_o && first < 0) first = j;
    end
    chk(first == 2, "R2 R3 restart from zero", first, 2);
    en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_disabled();
    t_rate(0, 0, 8'h00);
    t_rate(1, 2, 8'hFF);
    t_rate(2, 5, 8'hA5);
    t_rate(3, 0, 8'h00);
    t_rate(0, 7, 8'h3C);
    t_rate(3, 63, 8'h00);
    t_change();
    t_disable_mid();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule